// File: doc/BRIEF.md
# Pin Request and EOI Redelivery Engine

This block keeps the per-pin request state of an I/O interrupt router. Line events arrive one at a time on a small request port. Each event names a pin and its new level. The block keeps a pending-request bit (IRR) and a remote-request bit (remote IRR) for every pin. It reads each pin's mask, trigger mode and vector from static configuration inputs, decides when a delivery request is issued, and one cycle after each line event it reports whether that event was accepted or coalesced. Delivery requests leave on a valid/ready port. With the handshake the consumer also says whether at least one destination took the interrupt.

A broadcast end-of-interrupt (EOI) names a vector and a trigger mode. For a level-mode EOI, every pin programmed with that vector has its remote IRR cleared. Any such pin that is unmasked and still has its line asserted is redelivered. A per-pin counter tracks how many redeliveries happen back to back. When the counter reaches its limit, that redelivery is postponed. A single shared timer, loaded from a programmable cycle count, later retries every level pin that is still requesting. Destination decoding and register access are handled by other blocks.

Top module: `irq_pin_router`

## Requirements
- R1: A line event with level 0 clears the pin's IRR and is reported accepted (`line_coalesced_o` = 0). Every line event is answered by `line_done_o` high exactly one cycle later.
- R2: A level-1 event on an edge pin (trigger bit 0) whose IRR is already set is reported coalesced and adds no delivery request.
- R3: A level-1 event on a level pin (trigger bit 1) whose remote IRR is set sets IRR, is reported coalesced and adds no delivery request.
- R4: A pin whose mask bit is 1 never appears on the delivery port. Masking a pin withdraws its queued request.
- R5: An accepted level-1 event on an unmasked pin queues one delivery request. Completing the delivery of an edge pin clears its IRR, so the next level-1 event is accepted again.
- R6: Completing the delivery of a level pin with `deliv_taken_i` = 1 sets its remote IRR. With `deliv_taken_i` = 0 remote IRR stays clear.
- R7: An EOI with `eoi_level_i` = 1 and `directed_eoi_i` = 0 clears remote IRR on every pin whose vector equals `eoi_vector_i`. An EOI with `eoi_level_i` = 0, or with `directed_eoi_i` = 1, changes nothing.
- R8: After such an EOI clears remote IRR, an unmasked pin whose IRR is still set redelivers at once and its counter increments. Otherwise the counter goes to zero. The STORM_LIMIT-th consecutive redelivery is not issued: the counter returns to zero and a deferred retry is armed instead.
- R9: A deferred retry fires `retry_delay_i` cycles after it is armed (at least 1 cycle). It then queues a delivery for every unmasked level pin with IRR set and remote IRR clear. Only one retry can be armed at a time.
- R10: Only one delivery request is presented at a time, and it is always the lowest-numbered pin that is waiting. It stays presented, with the same pin, until `deliv_ready_i` is high, unless a lower pin becomes ready, the mask changes, or a line event arrives.
- R11: After reset every IRR and remote IRR bit is clear, no delivery is presented, no line response is given, and no retry is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_valid_i | input | 1 | A line event is presented this cycle |
| line_pin_i | input | PIN_W | Pin number of the line event |
| line_level_i | input | 1 | New line level (1 asserted) |
| line_done_o | output | 1 | Response to the event of the previous cycle |
| line_coalesced_o | output | 1 | 1 = that event was coalesced, 0 = accepted |
| pin_mask_i | input | NUM_PINS | Per-pin mask, 1 blocks delivery |
| pin_trig_i | input | NUM_PINS | Per-pin trigger mode, 0 edge, 1 level |
| pin_vector_i | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W upward |
| eoi_valid_i | input | 1 | Broadcast EOI this cycle |
| eoi_vector_i | input | VEC_W | Vector being acknowledged |
| eoi_level_i | input | 1 | Trigger mode of the EOI, 1 level |
| directed_eoi_i | input | 1 | 1 = broadcast EOIs leave remote IRR alone |
| retry_delay_i | input | DLY_W | Cycles from arming to firing a deferred retry |
| deliv_valid_o | output | 1 | Delivery request presented |
| deliv_ready_i | input | 1 | Consumer takes the request this cycle |
| deliv_taken_i | input | 1 | With ready: at least one destination accepted |
| deliv_pin_o | output | PIN_W | Pin being delivered |
| deliv_vector_o | output | VEC_W | Vector of that pin |
| deliv_level_o | output | 1 | Trigger mode of that pin |

## Verification
The assertions assume that line events and EOIs name pins inside NUM_PINS. They also assume that the mask, trigger and vector inputs only change while no delivery of the affected pin is in flight, so the hold rule only has to excuse mask changes and line events. The stimulus keeps these inputs fixed once the directed part starts. It issues one line event or one EOI at a time and drains every delivery before the next operation. After a deferral it waits past the retry delay, so retry expiry never overlaps a handshake the bench model does not expect.

// File: rtl/irq_route_pkg.sv
// Shared types for the pin request engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package irq_route_pkg;

    // Trigger mode of a pin, encoded as on the pin_trig_i inputs.
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

endpackage

// File: rtl/irq_pin_cell.sv
// One pin's request state: IRR, remote IRR, queued-delivery flag and the
// successive-redelivery counter. All events for this pin arrive pre-decoded.
// Assumes at most one line event per cycle and a handshake only while the
// pin is the one presented.
module irq_pin_cell
    import irq_route_pkg::*;
#(
    parameter int STORM_LIMIT = 10000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mask_i,
    input  trig_e trig_i,
    input  logic  set_hit_i,
    input  logic  set_level_i,
    input  logic  eoi_hit_i,
    input  logic  grant_i,
    input  logic  taken_i,
    input  logic  retry_i,
    output logic  irr_o,
    output logic  rirr_o,
    output logic  svc_o,
    output logic  defer_o,
    output logic  coal_o
);

    localparam int CNT_W = (STORM_LIMIT > 1) ? $clog2(STORM_LIMIT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STORM_LIMIT - 1);

    logic             irr_q, rirr_q, svc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irr_n, rirr_n, svc_n;
    logic [CNT_W-1:0] cnt_n;

    // Coalescing verdict for a level-1 event arriving now.
    assign coal_o  = set_level_i && ((trig_i == TRIG_EDGE) ? irr_q : rirr_q);
    // The redelivery that hits the storm limit is turned into a deferral.
    assign defer_o = eoi_hit_i && !mask_i && irr_q && (cnt_q == CNT_LAST);

    // Next-state: handshake, then EOI, then retry, then line event.
    always_comb begin
        irr_n  = irr_q;
        rirr_n = rirr_q;
        svc_n  = svc_q;
        cnt_n  = cnt_q;
        if (grant_i) begin
            svc_n = 1'b0;
            if (trig_i == TRIG_EDGE) begin
                irr_n = 1'b0;
            end else if (taken_i) begin
                rirr_n = 1'b1;
            end
        end
        if (eoi_hit_i) begin
            rirr_n = 1'b0;
            if (!mask_i && irr_q) begin
                if (cnt_q == CNT_LAST) begin
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                    svc_n = 1'b1;
                end
            end else begin
                cnt_n = '0;
            end
        end
        if (retry_i && (trig_i == TRIG_LEVEL) && irr_n && !rirr_n) begin
            svc_n = 1'b1;
        end
        if (set_hit_i) begin
            if (!set_level_i) begin
                irr_n = 1'b0;
            end else begin
                irr_n = 1'b1;
                if (!coal_o) begin
                    svc_n = 1'b1;
                end
            end
        end
        svc_n = svc_n && irr_n && !mask_i;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= 1'b0;
            rirr_q <= 1'b0;
            svc_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            irr_q  <= irr_n;
            rirr_q <= rirr_n;
            svc_q  <= svc_n;
            cnt_q  <= cnt_n;
        end
    end

    assign irr_o  = irr_q;
    assign rirr_o = rirr_q;
    assign svc_o  = svc_q;

endmodule

// File: rtl/irq_retry_timer.sv
// Single shared deferred-retry timer. Arming while idle loads the delay;
// arming while armed merges into the pending retry. fire_o pulses for one
// cycle when the count runs out. Assumes delay_i is stable while armed.
module irq_retry_timer #(
    parameter int DLY_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             fire_o
);

    logic             busy_q;
    logic [DLY_W-1:0] cnt_q;

    assign fire_o = busy_q && (cnt_q == DLY_W'(1));

    // Load, count down and retire the single pending retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (arm_i && (!busy_q || fire_o)) begin
            busy_q <= 1'b1;
            cnt_q  <= (delay_i == '0) ? DLY_W'(1) : delay_i;
        end else if (fire_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/irq_pick_lowest.sv
// Fixed-priority picker: the lowest set request bit wins.
// Assumes nothing about the request vector.
module irq_pick_lowest #(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan downward so the lowest set index is written last.
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_pin_router.sv
// Top of the pin request engine: decodes line events, EOIs and delivery
// handshakes per pin, replicates the pin cell, picks one delivery at a time
// and answers each line event one cycle later. Assumes configuration inputs
// are quasi-static and at most one line event and one EOI per cycle.
module irq_pin_router
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000,
    parameter int DLY_W       = 20
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                line_valid_i,
    input  logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0]  line_pin_i,
    input  logic                                                line_level_i,
    output logic                                                line_done_o,
    output logic                                                line_coalesced_o,
    input  logic [NUM_PINS-1:0]                                 pin_mask_i,
    input  logic [NUM_PINS-1:0]                                 pin_trig_i,
    input  logic [NUM_PINS*VEC_W-1:0]                           pin_vector_i,
    input  logic                                                eoi_valid_i,
    input  logic [VEC_W-1:0]                                    eoi_vector_i,
    input  logic                                                eoi_level_i,
    input  logic                                                directed_eoi_i,
    input  logic [DLY_W-1:0]                                    retry_delay_i,
    output logic                                                deliv_valid_o,
    input  logic                                                deliv_ready_i,
    input  logic                                                deliv_taken_i,
    output logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0]  deliv_pin_o,
    output logic [VEC_W-1:0]                                    deliv_vector_o,
    output logic                                                deliv_level_o
);

    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [VEC_W-1:0]    vec_arr [NUM_PINS];
    logic [NUM_PINS-1:0] set_hit, eoi_hit, grant;
    logic [NUM_PINS-1:0] irr_vec, rirr_vec, svc_vec, defer_vec, coal_vec;
    logic                retry_fire;
    logic                pin_ok;

    // Per-pin decode and state.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign vec_arr[g] = pin_vector_i[g*VEC_W +: VEC_W];
        assign set_hit[g] = line_valid_i && (line_pin_i == PIN_W'(g));
        assign eoi_hit[g] = eoi_valid_i && eoi_level_i && !directed_eoi_i
                            && (vec_arr[g] == eoi_vector_i);
        assign grant[g]   = deliv_valid_o && deliv_ready_i
                            && (deliv_pin_o == PIN_W'(g));

        irq_pin_cell #(
            .STORM_LIMIT (STORM_LIMIT)
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .mask_i      (pin_mask_i[g]),
            .trig_i      (trig_e'(pin_trig_i[g])),
            .set_hit_i   (set_hit[g]),
            .set_level_i (line_level_i),
            .eoi_hit_i   (eoi_hit[g]),
            .grant_i     (grant[g]),
            .taken_i     (deliv_taken_i),
            .retry_i     (retry_fire),
            .irr_o       (irr_vec[g]),
            .rirr_o      (rirr_vec[g]),
            .svc_o       (svc_vec[g]),
            .defer_o     (defer_vec[g]),
            .coal_o      (coal_vec[g])
        );
    end

    irq_retry_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (|defer_vec),
        .delay_i (retry_delay_i),
        .fire_o  (retry_fire)
    );

    irq_pick_lowest #(
        .N     (NUM_PINS),
        .IDX_W (PIN_W)
    ) u_pick (
        .req_i   (svc_vec & ~pin_mask_i),
        .valid_o (deliv_valid_o),
        .idx_o   (deliv_pin_o)
    );

    assign deliv_vector_o = vec_arr[deliv_pin_o];
    assign deliv_level_o  = pin_trig_i[deliv_pin_o];
    assign pin_ok         = (int'(line_pin_i) < NUM_PINS);

    // Line event response, one cycle after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_done_o      <= 1'b0;
            line_coalesced_o <= 1'b0;
        end else begin
            line_done_o      <= line_valid_i;
            line_coalesced_o <= line_valid_i && pin_ok && coal_vec[line_pin_i];
        end
    end

endmodule

// File: rtl/irq_pin_router_chk.sv
// Property checker for irq_pin_router, attached by bind below.
// Assumes pins named on the line port are below NUM_PINS.
module irq_pin_router_chk #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                line_valid_i,
    input logic [PIN_W-1:0]    line_pin_i,
    input logic                line_level_i,
    input logic                line_done_o,
    input logic                line_coalesced_o,
    input logic [NUM_PINS-1:0] pin_mask_i,
    input logic [NUM_PINS-1:0] pin_trig_i,
    input logic                deliv_valid_o,
    input logic                deliv_ready_i,
    input logic [PIN_W-1:0]    deliv_pin_o,
    input logic [NUM_PINS-1:0] irr_vec,
    input logic [NUM_PINS-1:0] rirr_vec
);

    // R1: every line event is answered the next cycle.
    p_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_i |=> line_done_o);

    // R1: a deassertion is never coalesced.
    p_release_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid_i && !line_level_i) |=> !line_coalesced_o);

    // R2: edge pin with IRR already set coalesces.
    p_edge_coal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid_i && line_level_i && !pin_trig_i[line_pin_i]
         && irr_vec[line_pin_i]) |=> line_coalesced_o);

    // R3: level pin with remote IRR set coalesces.
    p_level_coal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid_i && line_level_i && pin_trig_i[line_pin_i]
         && rirr_vec[line_pin_i]) |=> line_coalesced_o);

    // R4: a masked pin is never presented.
    p_mask_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        deliv_valid_o |-> !pin_mask_i[deliv_pin_o]);

    // R10: a presented request is held until ready.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (deliv_valid_o && !deliv_ready_i && !line_valid_i)
        |=> (deliv_valid_o && (deliv_pin_o <= $past(deliv_pin_o)))
            || (pin_mask_i != $past(pin_mask_i)));

endmodule

bind irq_pin_router irq_pin_router_chk #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .line_valid_i     (line_valid_i),
    .line_pin_i       (line_pin_i),
    .line_level_i     (line_level_i),
    .line_done_o      (line_done_o),
    .line_coalesced_o (line_coalesced_o),
    .pin_mask_i       (pin_mask_i),
    .pin_trig_i       (pin_trig_i),
    .deliv_valid_o    (deliv_valid_o),
    .deliv_ready_i    (deliv_ready_i),
    .deliv_pin_o      (deliv_pin_o),
    .irr_vec          (irr_vec),
    .rirr_vec         (rirr_vec)
);

// File: tb/irq_pin_router_tb_top.sv
// Bench: directed corner cases followed by seeded random line events and
// EOIs, checked against a behavioural model kept in bench tasks.
module irq_pin_router_tb_top;

    localparam int NP    = 4;
    localparam int VW    = 8;
    localparam int LIM   = 3;
    localparam int DW    = 8;
    localparam int PW    = 2;
    localparam int DELAY = 30;
    localparam logic [NP*VW-1:0] VECS = {8'h41, 8'h52, 8'h41, 8'h30};
    localparam logic [NP-1:0]    TRIG = 4'b1010;
    localparam logic [NP-1:0]    MASK = 4'b0100;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          line_valid_i, line_level_i;
    logic [PW-1:0] line_pin_i;
    logic          line_done_o, line_coalesced_o;
    logic          eoi_valid_i, eoi_level_i, directed_eoi_i;
    logic [VW-1:0] eoi_vector_i;
    logic          deliv_valid_o, deliv_ready_i, deliv_taken_i, deliv_level_o;
    logic [PW-1:0] deliv_pin_o;
    logic [VW-1:0] deliv_vector_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int e_cyc = 0;

    logic [NP-1:0] m_irr = '0, m_rirr = '0, m_svc = '0;
    int            m_cnt [NP];
    bit            m_defer = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_pin_router #(
        .NUM_PINS (NP), .VEC_W (VW), .STORM_LIMIT (LIM), .DLY_W (DW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .line_valid_i (line_valid_i), .line_pin_i (line_pin_i),
        .line_level_i (line_level_i), .line_done_o (line_done_o),
        .line_coalesced_o (line_coalesced_o),
        .pin_mask_i (MASK), .pin_trig_i (TRIG), .pin_vector_i (VECS),
        .eoi_valid_i (eoi_valid_i), .eoi_vector_i (eoi_vector_i),
        .eoi_level_i (eoi_level_i), .directed_eoi_i (directed_eoi_i),
        .retry_delay_i (DW'(DELAY)),
        .deliv_valid_o (deliv_valid_o), .deliv_ready_i (deliv_ready_i),
        .deliv_taken_i (deliv_taken_i), .deliv_pin_o (deliv_pin_o),
        .deliv_vector_o (deliv_vector_o), .deliv_level_o (deliv_level_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [NP-1:0] v);
        int r = 0;
        for (int i = NP - 1; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    // ---- model ----
    task automatic m_set(input int p, input bit lvl, output bit coal);
        coal = 1'b0;
        if (!lvl) begin
            m_irr[p] = 1'b0;
        end else begin
            coal = TRIG[p] ? m_rirr[p] : m_irr[p];
            m_irr[p] = 1'b1;
            if (!coal && !MASK[p]) m_svc[p] = 1'b1;
        end
        m_svc = m_svc & m_irr & ~MASK;
    endtask

    task automatic m_eoi(input logic [VW-1:0] v, input bit lvl, input bit dir);
        for (int p = 0; p < NP; p++) begin
            if (VECS[p*VW +: VW] == v && lvl && !dir) begin
                m_rirr[p] = 1'b0;
                if (!MASK[p] && m_irr[p]) begin
                    if (m_cnt[p] == LIM - 1) begin
                        m_cnt[p] = 0;
                        m_defer = 1'b1;
                    end else begin
                        m_cnt[p] = m_cnt[p] + 1;
                        m_svc[p] = 1'b1;
                    end
                end else begin
                    m_cnt[p] = 0;
                end
            end
        end
    endtask

    task automatic m_retry();
        for (int p = 0; p < NP; p++)
            if (TRIG[p] && m_irr[p] && !m_rirr[p] && !MASK[p]) m_svc[p] = 1'b1;
    endtask

    // ---- stimulus ----
    task automatic do_set(input int p, input bit lvl, input string req);
        bit c;
        @(negedge clk);
        line_valid_i = 1'b1; line_pin_i = PW'(p); line_level_i = lvl;
        @(negedge clk);
        line_valid_i = 1'b0;
        m_set(p, lvl, c);
        chk(line_done_o === 1'b1, req, int'(line_done_o), 1);
        chk(line_coalesced_o === c, req, int'(line_coalesced_o), int'(c));
    endtask

    task automatic do_eoi(input logic [VW-1:0] v, input bit lvl, input bit dir);
        @(negedge clk);
        eoi_valid_i = 1'b1; eoi_vector_i = v; eoi_level_i = lvl; directed_eoi_i = dir;
        @(negedge clk);
        eoi_valid_i = 1'b0; directed_eoi_i = 1'b0;
        m_eoi(v, lvl, dir);
        e_cyc = cyc;
    endtask

    // mode: 0 refuse, 1 take, 2 random
    task automatic drain(input int mode, input string req);
        for (int k = 0; k < NP + 2; k++) begin
            logic [NP-1:0] pend;
            int ep;
            bit tk;
            pend = m_svc & ~MASK;
            if (pend == '0) begin
                chk(deliv_valid_o === 1'b0, req, int'(deliv_valid_o), 0);
                break;
            end
            ep = lowest(pend);
            chk(deliv_valid_o === 1'b1 && int'(deliv_pin_o) == ep
                && deliv_vector_o == VECS[ep*VW +: VW] && deliv_level_o == TRIG[ep],
                req, int'(deliv_pin_o), ep);
            tk = (mode == 2) ? 1'($urandom_range(0, 1)) : (mode == 1);
            deliv_ready_i = 1'b1; deliv_taken_i = tk;
            @(negedge clk);
            deliv_ready_i = 1'b0; deliv_taken_i = 1'b0;
            m_svc[ep] = 1'b0;
            if (!TRIG[ep]) m_irr[ep] = 1'b0;
            else if (tk) m_rirr[ep] = 1'b1;
        end
    endtask

    task automatic finish_defer(input string req);
        if (m_defer) begin
            while (cyc < e_cyc + DELAY + 3) @(negedge clk);
            m_retry();
            m_defer = 1'b0;
            drain(2, req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int imm;
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) m_cnt[p] = 0;
        rst_n = 1'b0; line_valid_i = 1'b0; line_pin_i = '0; line_level_i = 1'b0;
        eoi_valid_i = 1'b0; eoi_vector_i = '0; eoi_level_i = 1'b0;
        directed_eoi_i = 1'b0; deliv_ready_i = 1'b0; deliv_taken_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(deliv_valid_o === 1'b0, "R11 no delivery after reset", int'(deliv_valid_o), 0);
        chk(line_done_o === 1'b0 && line_coalesced_o === 1'b0,
            "R11 no response after reset", int'(line_done_o), 0);

        // R5 edge delivery and IRR clearing
        do_set(0, 1, "R5 first edge accepted");
        drain(1, "R5 edge delivered");
        do_set(0, 1, "R5 IRR cleared by delivery");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(deliv_valid_o === 1'b1 && deliv_pin_o == 0, "R10 held until ready",
                int'(deliv_pin_o), 0);
        end
        drain(1, "R5 second edge delivered");
        do_set(0, 1, "R2 pending edge accepted");
        do_set(0, 1, "R2 pending edge coalesced");
        drain(1, "R2 exactly one delivery");

        // R4 / R2 / R1 on the masked edge pin
        do_set(2, 1, "R4 masked accepted");
        drain(1, "R4 masked pin not presented");
        do_set(2, 1, "R2 edge IRR set coalesced");
        do_set(2, 0, "R1 deassert accepted");
        do_set(2, 1, "R1 IRR cleared on deassert");
        drain(1, "R4 still not presented");

        // R6 / R3 on level pin 3
        do_set(3, 1, "R6 level accepted");
        drain(0, "R6 delivery refused");
        do_set(3, 1, "R6 no remote IRR after refusal");
        drain(1, "R6 delivery taken");
        do_set(3, 1, "R3 remote IRR coalesces");
        drain(1, "R3 no delivery");
        do_set(1, 1, "R5 level pin 1 accepted");
        drain(1, "R6 pin 1 taken");

        // R7 EOI filtering
        do_eoi(8'h41, 1'b0, 1'b0);
        drain(1, "R7 edge-mode EOI ignored");
        do_set(1, 1, "R7 remote IRR kept after edge EOI");
        do_eoi(8'h41, 1'b1, 1'b1);
        drain(1, "R7 directed mode ignores EOI");
        do_set(1, 1, "R7 remote IRR kept in directed mode");
        do_eoi(8'h30, 1'b1, 1'b0);
        drain(1, "R7 other vector untouched");
        do_eoi(8'h41, 1'b1, 1'b0);
        chk(deliv_valid_o === 1'b1 && deliv_pin_o == 1, "R10 lowest pin first",
            int'(deliv_pin_o), 1);
        drain(1, "R7 both matching pins redelivered");

        // R8 / R9 storm deferral
        do_set(1, 0, "R1 pin 1 released");
        do_set(3, 0, "R1 pin 3 released");
        do_eoi(8'h41, 1'b1, 1'b0);
        drain(1, "R8 counter cleared, nothing pending");
        do_set(1, 1, "R8 pin 1 asserted");
        drain(1, "R8 pin 1 taken");
        imm = 0;
        for (int k = 0; k < LIM + 1; k++) begin
            do_eoi(8'h41, 1'b1, 1'b0);
            if (m_defer) break;
            imm++;
            drain(1, "R8 immediate redelivery");
        end
        chk(imm == LIM - 1, "R8 immediate redeliveries before limit", imm, LIM - 1);
        repeat (10) @(negedge clk);
        chk(deliv_valid_o === 1'b0, "R8 limit redelivery deferred", int'(deliv_valid_o), 0);
        while (cyc < e_cyc + DELAY + 3) @(negedge clk);
        chk(deliv_valid_o === 1'b1 && deliv_pin_o == 1, "R9 retry after delay",
            int'(deliv_pin_o), 1);
        m_retry();
        m_defer = 1'b0;
        drain(1, "R9 retry delivered");
        do_eoi(8'h41, 1'b1, 1'b0);
        chk(!m_defer && deliv_valid_o === 1'b1, "R8 counter restarts after deferral",
            int'(deliv_valid_o), 1);
        drain(1, "R8 restart redelivery");

        // random phase
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 9) < 6) begin
                do_set(int'($urandom_range(0, NP - 1)), 1'($urandom_range(0, 1)),
                       "R1 R2 R3 R5 random line event");
                drain(2, "R4 R10 random drain");
            end else begin
                logic [VW-1:0] v;
                case ($urandom_range(0, 3))
                    0: v = 8'h30;
                    1: v = 8'h41;
                    2: v = 8'h52;
                    default: v = 8'h77;
                endcase
                do_eoi(v, 1'($urandom_range(0, 3) != 0), 1'b0);
                drain(2, "R7 R8 random EOI");
                finish_defer("R9 random retry");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule